// File: doc/BRIEF.md
# Fast-to-Slow Frozen-Capture Bus Crossing

This block carries a data bus from a fast clock domain into a slow clock domain without putting a synchronizer chain on any data bit. A small window generator samples the slow clock as a data signal on the fast clock. It passes that sample through a short shift register, which gives a copy of the slow clock delayed by a few fast cycles. A fast-domain hold register, one 2:1 mux per bit, follows the incoming data while this delayed copy is high and keeps its own value while it is low. The low phase of the delayed copy always spans the slow clock's rising edge. So the slow-domain output register, which loads from the hold register on every slow rising edge, always samples a settled value.

The block suits status words, counters and similar values where the slow side only needs a recent, coherent value. The fast side may change the bus on every cycle. Values that arrive between two freezes are skipped, and each slow cycle delivers the value held at the most recent freeze. Correct operation needs the slow period to exceed about 2·(SYNC_N+1) fast periods, which is 8:1 for the default of three stages.

Top module: `fs_lock_xfer`

## Requirements
- R1: While `rst` is high, the window stages and the hold register go to zero on each fast rising edge and `dout_slow` goes to zero on each slow rising edge.
- R2: The window is `clk_slow` delayed through SYNC_N fast-clock stages, SYNC_N being 3 by default. On a fast edge where the window was high, the hold register takes the value `din_fast` had at that edge.
- R3: On a fast edge where the window was low, the hold register keeps its value.
- R4: On each slow rising edge, `dout_slow` takes the hold register value captured at the window's most recent falling edge.
- R5: When `din_fast` changes on every fast cycle, intermediate values are skipped. Two successive slow outputs differ by more than one input step.
- R6: A value present on `din_fast` at one slow rising edge is reached or passed by `dout_slow` no later than the following slow rising edge. `dout_slow` never shows a value that `din_fast` has not yet presented.
- R7: With an incrementing source, `dout_slow` never decreases between successive slow edges after reset.
- R8: A constant `din_fast` appears unchanged on `dout_slow` within two slow cycles.
- R9: Raising `rst` during normal transfer returns `dout_slow` to zero. After release, transfer resumes with fresh values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Fast source-domain clock |
| clk_slow | input | 1 | Slow destination-domain clock, also sampled as data by the window stages |
| rst | input | 1 | Synchronous active-high reset, held across at least one edge of each clock |
| din_fast | input | DATA_W | Source data, fast domain |
| dout_slow | output | DATA_W | Transferred data, slow domain |

## Verification
The hardest case is a freeze that happens only a fraction of a fast period before a slow rising edge. Only a clock ratio near the limit produces it, and only certain phase relations between the two clocks. The stimulus runs the slow clock at 8.5, 14.5 and 30.5 fast periods, with an odd phase offset. This walks the freeze point across every fast-edge position relative to the slow edge without ever landing on a fast edge. A counting source makes every skipped, stale or torn capture show up as a wrong output value.

// File: rtl/fs_lock_xfer_pkg.sv
`timescale 1ns/1ps
package fs_lock_xfer_pkg;

    localparam int DEF_DATA_W = 16;
    localparam int DEF_SYNC_N = 3;

    // Select of the per-bit 2:1 mux in the hold register
    typedef enum logic {
        GATE_HOLD = 1'b0,
        GATE_LOAD = 1'b1
    } gate_e;

    function automatic gate_e gate_of(input logic window);
        return window ? GATE_LOAD : GATE_HOLD;
    endfunction

endpackage

// File: rtl/fs_lock_window.sv
`timescale 1ns/1ps
module fs_lock_window #(
    parameter int SYNC_N = fs_lock_xfer_pkg::DEF_SYNC_N
) (
    input  logic clk_fast,
    input  logic rst,
    input  logic clk_slow,
    output logic window
);
    logic [SYNC_N-1:0] stage_q;

    always_ff @(posedge clk_fast) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q <= {stage_q[SYNC_N-2:0], clk_slow};
        end
    end

    assign window = stage_q[SYNC_N-1];
endmodule

// File: rtl/fs_lock_hold.sv
`timescale 1ns/1ps
module fs_lock_hold
    import fs_lock_xfer_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk_fast,
    input  logic              rst,
    input  logic              window,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] hold_q
);
    gate_e gate;
    assign gate = gate_of(window);

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        logic mux_d;
        assign mux_d = (gate == GATE_LOAD) ? din[b] : hold_q[b];
        always_ff @(posedge clk_fast) begin
            if (rst) begin
                hold_q[b] <= 1'b0;
            end else begin
                hold_q[b] <= mux_d;
            end
        end
    end
endmodule

// File: rtl/fs_lock_dest.sv
`timescale 1ns/1ps
module fs_lock_dest #(
    parameter int DATA_W = fs_lock_xfer_pkg::DEF_DATA_W
) (
    input  logic              clk_slow,
    input  logic              rst,
    input  logic [DATA_W-1:0] src,
    output logic [DATA_W-1:0] dst_q
);
    always_ff @(posedge clk_slow) begin
        if (rst) begin
            dst_q <= '0;
        end else begin
            dst_q <= src;
        end
    end
endmodule

// File: rtl/fs_lock_xfer.sv
`timescale 1ns/1ps
module fs_lock_xfer
    import fs_lock_xfer_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int SYNC_N = DEF_SYNC_N
) (
    input  logic              clk_fast,
    input  logic              clk_slow,
    input  logic              rst,
    input  logic [DATA_W-1:0] din_fast,
    output logic [DATA_W-1:0] dout_slow
);
    logic              window;
    logic [DATA_W-1:0] lock_q;

    fs_lock_window #(.SYNC_N(SYNC_N)) u_window (
        .clk_fast (clk_fast),
        .rst      (rst),
        .clk_slow (clk_slow),
        .window   (window)
    );

    fs_lock_hold #(.DATA_W(DATA_W)) u_hold (
        .clk_fast (clk_fast),
        .rst      (rst),
        .window   (window),
        .din      (din_fast),
        .hold_q   (lock_q)
    );

    fs_lock_dest #(.DATA_W(DATA_W)) u_dest (
        .clk_slow (clk_slow),
        .rst      (rst),
        .src      (lock_q),
        .dst_q    (dout_slow)
    );
endmodule

// File: rtl/fs_lock_xfer_chk.sv
`timescale 1ns/1ps
module fs_lock_xfer_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk_fast,
    input logic              clk_slow,
    input logic              rst,
    input logic [DATA_W-1:0] din_fast,
    input logic [DATA_W-1:0] dout_slow,
    input logic              window,
    input logic [DATA_W-1:0] lock_q
);
    AST_FAST_RESET: assert property (@(posedge clk_fast) disable iff (rst)
        $past(rst) |-> (window == 1'b0 && lock_q == '0)); // R1

    AST_SLOW_RESET: assert property (@(posedge clk_slow) disable iff (rst)
        $past(rst) |-> dout_slow == '0); // R1

    AST_LOCK_LOAD: assert property (@(posedge clk_fast) disable iff (rst)
        (!$past(rst) && $past(window)) |-> lock_q == $past(din_fast)); // R2

    AST_LOCK_FROZEN: assert property (@(posedge clk_fast) disable iff (rst)
        (!$past(rst) && !$past(window)) |-> $stable(lock_q)); // R3

    AST_DEST_TRACK: assert property (@(posedge clk_slow) disable iff (rst)
        !$past(rst) |-> dout_slow == $past(lock_q)); // R4
endmodule

bind fs_lock_xfer fs_lock_xfer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk_fast  (clk_fast),
    .clk_slow  (clk_slow),
    .rst       (rst),
    .din_fast  (din_fast),
    .dout_slow (dout_slow),
    .window    (window),
    .lock_q    (lock_q)
);

// File: tb/test_fs_lock_xfer.sv
`timescale 1ns/1ps
module test_fs_lock_xfer;
    localparam int W = 16;
    localparam int N = 3;

    typedef struct packed {
        logic [15:0]  half;
        logic [15:0]  edges;
        logic [W-1:0] step;
        logic         hmode;
        logic [W-1:0] hval;
    } vec_t;

    // slow half period (ns), slow edges, increment, hold mode, hold value
    localparam vec_t VECS [6] = '{
        '{16'd85,  16'd30, 16'd1, 1'b0, 16'h0000},
        '{16'd145, 16'd30, 16'd1, 1'b0, 16'h0000},
        '{16'd305, 16'd20, 16'd1, 1'b0, 16'h0000},
        '{16'd85,  16'd30, 16'd5, 1'b0, 16'h0000},
        '{16'd145, 16'd12, 16'd0, 1'b1, 16'hA5C3},
        '{16'd85,  16'd30, 16'd1, 1'b0, 16'h0000}
    };

    logic         clk_fast = 1'b0;
    logic         clk_slow = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout;

    int unsigned  half = 85;
    logic [W-1:0] step = '0;
    logic [W-1:0] hold = '0;
    logic         hold_mode = 1'b0;
    int           vectors = 0;
    int           fails = 0;
    bit           done = 1'b0;

    fs_lock_xfer #(.DATA_W(W), .SYNC_N(N)) i_fs_lock_xfer (
        .clk_fast  (clk_fast),
        .clk_slow  (clk_slow),
        .rst       (rst),
        .din_fast  (din),
        .dout_slow (dout)
    );

    always #10 clk_fast = ~clk_fast;

    // Half periods are 5 mod 20 with a 3 ns offset: slow edges never meet fast edges
    initial begin
        #3;
        forever begin
            #(half) clk_slow = ~clk_slow;
        end
    end

    initial begin
        forever begin
            @(negedge clk_fast);
            if (hold_mode) din <= hold;
            else           din <= din + step;
        end
    end

    // Reference: window = slow clock delayed N fast edges; capture at its falling edge
    logic [N-1:0] mwin = '0;
    logic [W-1:0] cap = '0;
    always @(posedge clk_fast) begin
        if (rst) begin
            mwin <= '0;
            cap  <= '0;
        end else begin
            mwin <= {mwin[N-2:0], clk_slow};
            if (mwin[N-1] && !mwin[N-2]) cap <= din;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    logic [W-1:0] prev_dout;
    logic [W-1:0] prev_din;

    initial begin
        // R1: reset state
        repeat (3) begin
            @(posedge clk_slow); #1;
            chk(dout == '0, "R1 reset", dout, '0);
        end
        @(negedge clk_fast); rst = 1'b0;
        prev_dout = '0;
        prev_din  = '0;

        for (int i = 0; i < 6; i++) begin
            @(negedge clk_fast);
            half      = int'(VECS[i].half);
            step      = VECS[i].step;
            hold      = VECS[i].hval;
            hold_mode = VECS[i].hmode;
            for (int k = 0; k < int'(VECS[i].edges); k++) begin
                @(posedge clk_slow); #1;
                chk(dout == cap, "R2 R3 R4 capture", dout, cap);
                if (!hold_mode && k >= 1)
                    chk(dout >= prev_dout, "R7 monotonic", dout, prev_dout);
                if (!hold_mode && k >= 2) begin
                    chk(dout - prev_dout > step, "R5 skip", dout - prev_dout, step);
                    chk(dout >= prev_din, "R6 latency", dout, prev_din);
                    chk(dout <= din, "R6 no future", dout, din);
                end
                if (hold_mode && k == int'(VECS[i].edges) - 1)
                    chk(dout == hold, "R8 constant", dout, hold);
                prev_dout = dout;
                prev_din  = din;
            end
        end

        // R9: reset during transfer
        @(negedge clk_fast); rst = 1'b1;
        repeat (2) begin
            @(posedge clk_slow); #1;
            chk(dout == '0, "R9 reset mid-run", dout, '0);
        end
        @(negedge clk_fast); rst = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(posedge clk_slow); #1;
            chk(dout == cap, "R9 resume capture", dout, cap);
            if (k == 5) chk(dout != '0, "R9 resume nonzero", dout, cap);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule